// File: doc/BRIEF.md
# EPP Cycle Controller

This block sits next to the printer-port registers and turns host accesses at two extra offsets into enhanced-parallel-port byte handshakes. Offset 3 runs address cycles and offset 4 runs data cycles. It also holds the data, status and control registers that share the port. A cycle starts only when the control register is in the exact mode for its direction. Otherwise the access completes at once with no activity on the port.

Each byte cycle sets the write level and the data first, then raises an address or data strobe. It holds the strobe until the peripheral raises wait, drops the strobe, and then waits for wait to fall. Either wait phase that lasts a parameterised number of clocks aborts the access and sets a sticky timeout flag. The flag shows in status bit 0 and is cleared only by software. At offset 4, 16-bit and 32-bit host accesses become 2 or 4 byte cycles in little-endian order.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset the control register reads 0xCC, the timeout flag is 0, `ppDataOut` is 0xFF, `ppDataOe` is 1 and `ctrlLines` is 4'hC.
- R2: A write at offset 3 or 4 runs byte cycles only when control bits {5,3,2,1,0} equal 0,0,1,0,0. In any other mode it causes no strobe and no byte on the port, and it still completes.
- R3: A read at offset 3 or 4 runs byte cycles only when control bits {5,3,2,1,0} equal 1,0,1,0,0. In any other mode it returns 0xFFFFFFFF with no strobe.
- R4: Offset 3 cycles use `eppAddrStb` and offset 4 cycles use `eppDataStb`. The two strobes are never high together.
- R5: In each byte cycle, `eppWrite` and the write byte are set one clock before the strobe rises and stay stable while it is high. The strobe stays high until `eppWait` is seen high. The next byte or the completion waits for `eppWait` low.
- R6: `hostSize` 0, 1 and 2 give 1, 2 and 4 byte cycles at offset 4, least significant byte first. A read places byte k in bits [8k+7:8k], and bytes not received read as ones. Offset 3 always uses one byte.
- R7: If `eppWait` does not change within TMO_CYCLES clocks in either wait phase, the access ends, the timeout flag is set and the remaining bytes are skipped.
- R8: A status read (offset 1) returns `ppStatus` bits 7:1 with bit 0 replaced by the timeout flag.
- R9: The timeout flag is cleared only by a status write with bit 0 = 1. A status write with bit 0 = 0 leaves it set.
- R10: A data (offset 0) or control (offset 2) write that changes the stored value gives one `linesChg` pulse. A write that repeats the stored value gives none.
- R11: Control bits 7:6 always read 1. `ppDataOe` equals the inverse of control bit 5.
- R12: `hostDone` pulses one clock after a register access or a mode-gated access is accepted. For an access that runs n byte cycles, it pulses 1+7n clocks after acceptance when the peripheral raises wait 3 clocks after each strobe and drops it 1 clock after release. For an access that times out in its first byte, it pulses TMO_CYCLES+2 clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| hostReq | input | 1 | one-clock access request, taken when idle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 3 | register offset (0 data, 1 status, 2 control, 3 address cycle, 4 data cycle) |
| hostSize | input | 2 | 0 byte, 1 half word, 2 word (offset 4 only) |
| hostWdata | input | 32 | write data |
| hostRdata | output | 32 | read result, valid with hostDone |
| hostDone | output | 1 | one-clock completion pulse |
| ppDataIn | input | 8 | port data bus as seen on the pins |
| ppDataOut | output | 8 | port data bus drive value |
| ppDataOe | output | 1 | port data bus output enable |
| ppStatus | input | 8 | peripheral status lines |
| ctrlLines | output | 4 | control register bits 3:0 to the port |
| linesChg | output | 1 | pulse when the data or control register value changes |
| eppWrite | output | 1 | write level of the current byte cycle |
| eppAddrStb | output | 1 | address strobe |
| eppDataStb | output | 1 | data strobe |
| eppWait | input | 1 | peripheral wait handshake |

## Verification
Register and gated accesses must show `hostDone` at the first negative edge after the accepting clock. The driver task checks this by sampling once, right after it drops the request. For byte-cycle accesses, the bench's peripheral raises wait three clocks after it sees the strobe and drops it one clock after release. This makes each byte cost seven clocks, so the driver counts negative edges until `hostDone` and expects 1+7n, or TMO_CYCLES+2 on a stalled first byte. Read words are compared by a monitor that pops a queue at each `hostDone`. Port-side effects are compared only after the access has finished and one more clock has passed: the logged bytes, strobe rises and `linesChg` pulses.

// File: rtl/epp_pkg.sv
package epp_pkg;

  // mode bits compared for gating: dir(5), select(3), init(2), autolf(1), strobe(0)
  localparam logic [7:0] MODE_MASK  = 8'h2F;
  localparam logic [7:0] MODE_WRITE = 8'h04;
  localparam logic [7:0] MODE_READ  = 8'h24;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam logic [7:0] CTRL_RESET = 8'hCC;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_ADDR = 3'd3;
  localparam logic [2:0] OFF_EPPD = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STB,
    ST_REL
  } eppSt_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic regOp;      // register or gated access, uses live host inputs
    logic eppStart;   // load write word, preset read word
    logic byteCap;    // capture port byte into read word
    logic byteShift;  // move to next write byte
    logic tmoSet;     // wait phase expired
    logic doneP;      // access complete
    logic busy;       // byte cycles in progress
  } eppStb_t;

endpackage

// File: rtl/epp_ctl.sv
module epp_ctl
  import epp_pkg::*;
#(
  parameter int TMO_CYCLES = 2000,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
  localparam int CNT_W = $clog2(TMO_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReq,
  input  logic             hostWr,
  input  logic [2:0]       hostAddr,
  input  logic [1:0]       hostSize,
  input  logic             modeWrOk,
  input  logic             modeRdOk,
  input  logic             eppWait,
  output eppStb_t          stb,
  output logic [IDX_W-1:0] byteIdx,
  output logic             eppWrite,
  output logic             eppAddrStb,
  output logic             eppDataStb
);

  eppSt_t st, stNext;
  logic isWr, isAddr;
  logic [IDX_W-1:0] lastIdx, lastIdxNext;
  logic [CNT_W-1:0] cnt;
  logic cntClr, cntInc, idxInc;
  logic isEppOff, gateOk, expired;

  assign isEppOff = (hostAddr == OFF_ADDR) || (hostAddr == OFF_EPPD);
  assign gateOk   = hostWr ? modeWrOk : modeRdOk;
  assign expired  = (cnt == CNT_W'(TMO_CYCLES - 1));

  always_comb begin
    if (hostAddr == OFF_ADDR) lastIdxNext = '0;
    else begin
      case (hostSize)
        2'd0:    lastIdxNext = '0;
        2'd1:    lastIdxNext = IDX_W'(1);
        default: lastIdxNext = IDX_W'(WORD_BYTES - 1);
      endcase
    end
  end

  always_comb begin
    stNext = st;
    stb    = '0;
    cntClr = 1'b0;
    cntInc = 1'b0;
    idxInc = 1'b0;
    stb.busy = (st != ST_IDLE);
    case (st)
      ST_IDLE: begin
        if (hostReq) begin
          if (isEppOff && gateOk) begin
            stb.eppStart = 1'b1;
            stNext = ST_SETUP;
          end else begin
            stb.regOp = 1'b1;
            stb.doneP = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        cntClr = 1'b1;
        stNext = ST_STB;
      end
      ST_STB: begin
        if (eppWait) begin
          stb.byteCap = !isWr;
          cntClr = 1'b1;
          stNext = ST_REL;
        end else if (expired) begin
          stb.tmoSet = 1'b1;
          stb.doneP  = 1'b1;
          stNext = ST_IDLE;
        end else cntInc = 1'b1;
      end
      ST_REL: begin
        if (!eppWait) begin
          if (byteIdx == lastIdx) begin
            stb.doneP = 1'b1;
            stNext = ST_IDLE;
          end else begin
            stb.byteShift = 1'b1;
            idxInc = 1'b1;
            stNext = ST_SETUP;
          end
        end else if (expired) begin
          stb.tmoSet = 1'b1;
          stb.doneP  = 1'b1;
          stNext = ST_IDLE;
        end else cntInc = 1'b1;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      isWr    <= 1'b0;
      isAddr  <= 1'b0;
      lastIdx <= '0;
      byteIdx <= '0;
      cnt     <= '0;
    end else begin
      st <= stNext;
      if (stb.eppStart) begin
        isWr    <= hostWr;
        isAddr  <= (hostAddr == OFF_ADDR);
        lastIdx <= lastIdxNext;
        byteIdx <= '0;
      end else if (idxInc) byteIdx <= byteIdx + 1'b1;
      if (cntClr) cnt <= '0;
      else if (cntInc) cnt <= cnt + 1'b1;
    end
  end

  assign eppWrite   = (st != ST_IDLE) && isWr;
  assign eppAddrStb = (st == ST_STB) && isAddr;
  assign eppDataStb = (st == ST_STB) && !isAddr;

endmodule

// File: rtl/epp_dp.sv
module epp_dp
  import epp_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
  localparam int WORD_W = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  eppStb_t           stb,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic              hostWr,
  input  logic [2:0]        hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic [7:0]        ppDataIn,
  input  logic [7:0]        ppStatus,
  output logic [WORD_W-1:0] hostRdata,
  output logic              hostDone,
  output logic [7:0]        ppDataOut,
  output logic              ppDataOe,
  output logic [3:0]        ctrlLines,
  output logic              linesChg,
  output logic              modeWrOk,
  output logic              modeRdOk
);

  logic [7:0] ctrlReg, dataReg, ctrlNew, statView;
  logic tmoFlag;
  logic [WORD_W-1:0] shiftReg, rdWord;

  assign ctrlNew  = hostWdata[7:0] | CTRL_FIXED;
  assign statView = (ppStatus & 8'hFE) | {7'b0, tmoFlag};
  assign modeWrOk = (ctrlReg & MODE_MASK) == MODE_WRITE;
  assign modeRdOk = (ctrlReg & MODE_MASK) == MODE_READ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RESET;
      dataReg  <= 8'hFF;
      tmoFlag  <= 1'b0;
      shiftReg <= '0;
      rdWord   <= '0;
      hostDone <= 1'b0;
      linesChg <= 1'b0;
    end else begin
      hostDone <= stb.doneP;
      linesChg <= 1'b0;
      if (stb.regOp) begin
        if (hostWr) begin
          rdWord <= '0;
          case (hostAddr)
            OFF_DATA: if (hostWdata[7:0] != dataReg) begin
              dataReg  <= hostWdata[7:0];
              linesChg <= 1'b1;
            end
            OFF_STAT: if (hostWdata[0]) tmoFlag <= 1'b0;
            OFF_CTRL: if (ctrlNew != ctrlReg) begin
              ctrlReg  <= ctrlNew;
              linesChg <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          case (hostAddr)
            OFF_DATA: rdWord <= WORD_W'(ctrlReg[5] ? ppDataIn : dataReg);
            OFF_STAT: rdWord <= WORD_W'(statView);
            OFF_CTRL: rdWord <= WORD_W'(ctrlReg);
            default:  rdWord <= '1;
          endcase
        end
      end
      if (stb.eppStart) begin
        shiftReg <= hostWdata;
        rdWord   <= '1;
      end
      if (stb.byteCap) rdWord[{byteIdx, 3'b000} +: 8] <= ppDataIn;
      if (stb.byteShift) shiftReg <= shiftReg >> 8;
      if (stb.tmoSet) tmoFlag <= 1'b1;
    end
  end

  assign hostRdata = rdWord;
  assign ppDataOut = stb.busy ? shiftReg[7:0] : dataReg;
  assign ppDataOe  = !ctrlReg[5];
  assign ctrlLines = ctrlReg[3:0];

endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int TMO_CYCLES = 2000,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
  localparam int WORD_W = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [2:0]        hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              hostDone,
  input  logic [7:0]        ppDataIn,
  output logic [7:0]        ppDataOut,
  output logic              ppDataOe,
  input  logic [7:0]        ppStatus,
  output logic [3:0]        ctrlLines,
  output logic              linesChg,
  output logic              eppWrite,
  output logic              eppAddrStb,
  output logic              eppDataStb,
  input  logic              eppWait
);

  eppStb_t stb;
  logic [IDX_W-1:0] byteIdx;
  logic modeWrOk, modeRdOk;

  epp_ctl #(.TMO_CYCLES(TMO_CYCLES), .WORD_BYTES(WORD_BYTES)) ctl_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .modeWrOk(modeWrOk),
    .modeRdOk(modeRdOk), .eppWait(eppWait), .stb(stb), .byteIdx(byteIdx),
    .eppWrite(eppWrite), .eppAddrStb(eppAddrStb), .eppDataStb(eppDataStb)
  );

  epp_dp #(.WORD_BYTES(WORD_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIdx(byteIdx), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .ppDataIn(ppDataIn),
    .ppStatus(ppStatus), .hostRdata(hostRdata), .hostDone(hostDone),
    .ppDataOut(ppDataOut), .ppDataOe(ppDataOe), .ctrlLines(ctrlLines),
    .linesChg(linesChg), .modeWrOk(modeWrOk), .modeRdOk(modeRdOk)
  );

endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       eppWrite,
  input logic       eppAddrStb,
  input logic       eppDataStb,
  input logic [7:0] ppDataOut,
  input logic       ppDataOe,
  input logic [3:0] ctrlLines
);

  logic anyStb;
  assign anyStb = eppAddrStb || eppDataStb;

  // R4: only one strobe at a time
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(eppAddrStb && eppDataStb));

  // R2: write strobes only in the write mode (bus driven, init only)
  a_r2_write_gate: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && eppWrite) |-> (ppDataOe && ctrlLines == 4'b0100));

  // R3: read strobes only in the read mode (bus released, init only)
  a_r3_read_gate: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && !eppWrite) |-> (!ppDataOe && ctrlLines == 4'b0100));

  // R5: write level and byte hold while the strobe is high
  a_r5_stable_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && $past(anyStb)) |-> ($stable(eppWrite) && $stable(ppDataOut)));

endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .eppWrite(eppWrite), .eppAddrStb(eppAddrStb),
  .eppDataStb(eppDataStb), .ppDataOut(ppDataOut), .ppDataOe(ppDataOe),
  .ctrlLines(ctrlLines)
);

// File: tb/epp_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_tb_top;

  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 1'b0, hostWr = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [1:0] hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic hostDone;
  logic [7:0] ppDataOut, ppStatus = 8'h81;
  logic [7:0] rdSrc = 8'h30;
  logic ppDataOe, linesChg, eppWrite, eppAddrStb, eppDataStb;
  logic [3:0] ctrlLines;
  logic waitR = 1'b0, stall = 1'b0, prevStb = 1'b0;
  int dly = 0;
  int total = 0, bad = 0, chgCnt = 0, stbRises = 0;
  bit finished = 0;

  logic [31:0] expVal[$];
  bit          expChk[$];
  string       expTag[$];
  logic [8:0]  wrLog[$];

  always #2.5 clk = ~clk;

  epp_cycle_ctrl #(.TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostDone(hostDone), .ppDataIn(rdSrc),
    .ppDataOut(ppDataOut), .ppDataOe(ppDataOe), .ppStatus(ppStatus),
    .ctrlLines(ctrlLines), .linesChg(linesChg), .eppWrite(eppWrite),
    .eppAddrStb(eppAddrStb), .eppDataStb(eppDataStb), .eppWait(waitR)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // peripheral model: wait rises 3 clocks after strobe, falls 1 clock after release
  always @(posedge clk) begin
    if (!rstN) begin
      waitR <= 1'b0; dly <= 0; prevStb <= 1'b0;
    end else begin
      prevStb <= eppAddrStb || eppDataStb;
      if ((eppAddrStb || eppDataStb) && !prevStb) stbRises <= stbRises + 1;
      if (linesChg) chgCnt <= chgCnt + 1;
      if ((eppAddrStb || eppDataStb) && !waitR) begin
        if (!stall) begin
          if (dly == 2) begin
            waitR <= 1'b1; dly <= 0;
            if (eppWrite) wrLog.push_back({eppAddrStb, ppDataOut});
          end else dly <= dly + 1;
        end
      end else if (!(eppAddrStb || eppDataStb) && waitR) begin
        waitR <= 1'b0;
        if (!eppWrite) rdSrc <= rdSrc + 8'd1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && hostDone) begin
      if (expVal.size() == 0) chk(1'b0, "R12 unexpected done", 32'h0, 32'h0);
      else begin
        logic [31:0] e; bit c; string t;
        e = expVal.pop_front(); c = expChk.pop_front(); t = expTag.pop_front();
        if (c) chk(hostRdata === e, t, hostRdata, e);
      end
    end
  end

  task automatic access(input bit wr, input logic [2:0] addr, input logic [1:0] size,
                        input logic [31:0] wdata, input logic [31:0] expv,
                        input int lat, input string tag);
    int cyc;
    expVal.push_back(expv); expChk.push_back(!wr); expTag.push_back(tag);
    @(negedge clk);
    hostReq = 1'b1; hostWr = wr; hostAddr = addr; hostSize = size; hostWdata = wdata;
    @(negedge clk);
    hostReq = 1'b0;
    cyc = 1;
    while (!hostDone) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == lat, {"R12 latency ", tag}, cyc, lat);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic logCheck(input logic [8:0] exp[$], input string tag);
    chk(wrLog.size() == exp.size(), {tag, " byte count"}, wrLog.size(), exp.size());
    for (int i = 0; i < exp.size() && i < wrLog.size(); i++)
      chk(wrLog[i] == exp[i], tag, {23'b0, wrLog[i]}, {23'b0, exp[i]});
    wrLog.delete();
  endtask

  initial begin
    int c0, s0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(ppDataOe == 1'b1, "R1 oe", {31'b0, ppDataOe}, 32'h1);
    chk(ctrlLines == 4'hC, "R1 ctrl lines", {28'b0, ctrlLines}, 32'hC);
    chk(ppDataOut == 8'hFF, "R1 data out", {24'b0, ppDataOut}, 32'hFF);
    access(0, 3'd2, 2'd0, 0, 32'h000000CC, 1, "R1 ctrl reset");
    access(0, 3'd1, 2'd0, 0, 32'h00000080, 1, "R8 R1 status bit0 is flag");

    // gated write in reset mode
    access(1, 3'd4, 2'd2, 32'h12345678, 0, 1, "R2 gated write");
    chk(stbRises == 0, "R2 no strobe", stbRises, 0);
    logCheck('{}, "R2 no bytes");
    access(0, 3'd3, 2'd0, 0, 32'hFFFFFFFF, 1, "R3 gated read");

    // enter write mode
    c0 = chgCnt;
    access(1, 3'd2, 2'd0, 32'h04, 0, 1, "R10 ctrl change");
    chk(chgCnt == c0 + 1, "R10 change pulse", chgCnt, c0 + 1);
    access(0, 3'd2, 2'd0, 0, 32'h000000C4, 1, "R11 ctrl fixed bits");

    access(1, 3'd3, 2'd0, 32'hA5, 0, 8, "R4 addr write");
    logCheck('{9'h1A5}, "R4 addr strobe byte");
    access(1, 3'd4, 2'd2, 32'h11223344, 0, 29, "R6 word write");
    logCheck('{9'h044, 9'h033, 9'h022, 9'h011}, "R6 word order");
    access(1, 3'd4, 2'd1, 32'h0000BEEF, 0, 15, "R6 half write");
    logCheck('{9'h0EF, 9'h0BE}, "R6 half order");
    access(0, 3'd4, 2'd2, 0, 32'hFFFFFFFF, 1, "R3 read in write mode");

    // enter read mode
    c0 = chgCnt;
    access(1, 3'd2, 2'd0, 32'h24, 0, 1, "R11 dir change");
    chk(ppDataOe == 1'b0, "R11 bus released", {31'b0, ppDataOe}, 32'h0);
    access(1, 3'd2, 2'd0, 32'h24, 0, 1, "R10 ctrl repeat");
    chk(chgCnt == c0 + 1, "R10 repeat ctrl no pulse", chgCnt, c0 + 1);
    access(1, 3'd0, 2'd0, 32'h5A, 0, 1, "R10 data change");
    access(1, 3'd0, 2'd0, 32'h5A, 0, 1, "R10 data repeat");
    chk(chgCnt == c0 + 2, "R10 repeat data no pulse", chgCnt, c0 + 2);

    s0 = stbRises;
    access(1, 3'd4, 2'd0, 32'h77, 0, 1, "R2 write in read mode");
    chk(stbRises == s0, "R2 no strobe in read mode", stbRises, s0);
    logCheck('{}, "R2 no bytes in read mode");

    access(0, 3'd3, 2'd0, 0, 32'hFFFFFF30, 8, "R4 R6 addr read");
    access(0, 3'd4, 2'd2, 0, 32'h34333231, 29, "R6 word read");
    access(0, 3'd4, 2'd1, 0, 32'hFFFF3635, 15, "R6 half read");

    // timeout
    stall = 1'b1;
    s0 = stbRises;
    access(0, 3'd4, 2'd2, 0, 32'hFFFFFFFF, TMO + 2, "R7 timeout read");
    chk(stbRises == s0 + 1, "R7 rest skipped", stbRises, s0 + 1);
    stall = 1'b0;
    access(0, 3'd1, 2'd0, 0, 32'h00000081, 1, "R7 R8 flag set");
    ppStatus = 8'h40;
    access(0, 3'd1, 2'd0, 0, 32'h00000041, 1, "R8 bit0 replaced");
    access(1, 3'd1, 2'd0, 32'h00, 0, 1, "R9 write zero");
    access(0, 3'd1, 2'd0, 0, 32'h00000041, 1, "R9 flag sticky");
    access(1, 3'd1, 2'd0, 32'h01, 0, 1, "R9 write one");
    access(0, 3'd1, 2'd0, 0, 32'h00000040, 1, "R9 flag cleared");

    chk(expVal.size() == 0, "R12 all results seen", expVal.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule